// File: doc/BRIEF.md
# Built-in-Test Fault Monitor for a Tracking Angle Converter

This block watches the health of a tracking angle converter and drives one active-low fault flag. It takes three digital words on every sample strobe. The first is the signed tracking error, counted in LSBs of the 16-bit angle. The other two are rectified amplitude measures of the sensor signal and of the excitation reference. A strobe captures all three words together, and they are held until the next strobe.

A large tracking error is normal for a short time, for example after a step in angle or at power-up. For that reason the error condition must last through a time filter of about 500 µs before it can pull the flag low. The filter length is worked out from the clock frequency. A sensor signal or a reference that falls below its programmed floor pulls the flag low with no filtering. The flag returns high on the first cycle after a sample in which all three conditions are clear.

Top module: `bit_fault_monitor`

## Requirements
- R1: Inputs `err_in`, `sig_amp` and `ref_amp` are captured only on a clock edge where `smp_vld` is 1. Between strobes the captured values, and so the flag, do not change.
- R2: The error condition holds when the magnitude of the captured two's-complement error is strictly greater than ERR_LIMIT (default 100). An error of -32768 counts as a magnitude of 32768.
- R3: When the error condition is the only one present, `fault_n` stays high for FILT_CYC clock edges after the capture edge and goes low on edge FILT_CYC+1. FILT_CYC = CLK_HZ/1_000_000 × FILT_US.
- R4: A captured sample that clears the error condition restarts the filter. A later error then needs the full FILT_CYC+1 edges again.
- R5: A captured `sig_amp` below SIG_FLOOR (loss of signal) drives `fault_n` low on the first clock edge after the capture edge.
- R6: A captured `ref_amp` below REF_FLOOR (loss of reference) drives `fault_n` low on the first clock edge after the capture edge.
- R7: `fault_n` is 0 for a fault and 1 for healthy. It returns to 1 on the first edge after the capture edge of a sample in which all conditions are clear.
- R8: While `rst_n` is 0, `fault_n` is 1. The captured error resets to 0, the captured amplitudes reset to all ones, and the filter resets to zero.
- R9: An amplitude exactly equal to its floor is not a loss. The default floors equal 500 mV at a full scale of AMP_FS_MV (default 4000 mV over 2^AMP_W codes), which gives code 512 at 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe; captures all three words |
| err_in | input | ERR_W | Signed tracking error in angle LSBs |
| sig_amp | input | AMP_W | Unsigned sensor signal amplitude measure |
| ref_amp | input | AMP_W | Unsigned reference amplitude measure |
| fault_n | output | 1 | Fault flag, 0 when a fault is present |

## Verification
The embedded assertions check these rules on every cycle:
- Captured words hold between strobes.
- The filter count never passes its terminal value.
- The filter clears on the cycle after the error condition drops.
- Either amplitude loss pulls the flag low on the next edge.
- The flag is released on the next edge once all conditions are clear.

Only the bench scenarios can show the exact delay of the filter, measured in edges from the capture edge. The same holds for the restart after an interrupted error, the threshold boundaries at ±100, ±101 and -32768, and the equal-to-floor case.

// File: rtl/bit_mon_pkg.sv
package bit_mon_pkg;

   // Magnitude of a signed word, one bit wider so the most negative value fits
   function automatic logic [16:0] mag16(input logic signed [15:0] v);
      logic signed [16:0] w;
      w = 17'(v);
      return (w < 0) ? 17'(-w) : 17'(w);
   endfunction

   typedef struct packed {
      logic err_hi;
      logic sig_low;
      logic ref_low;
   } cond_t;

endpackage

// File: rtl/bit_sample_reg.sv
module bit_sample_reg #(
   parameter int ERR_W = 16,
   parameter int AMP_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_vld,
   input  logic signed [ERR_W-1:0] err_in,
   input  logic        [AMP_W-1:0] sig_amp,
   input  logic        [AMP_W-1:0] ref_amp,
   output logic signed [ERR_W-1:0] err_q,
   output logic        [AMP_W-1:0] sig_q,
   output logic        [AMP_W-1:0] ref_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
         sig_q <= '1;
         ref_q <= '1;
      end else if (smp_vld) begin
         err_q <= err_in;
         sig_q <= sig_amp;
         ref_q <= ref_amp;
      end
   end

   AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(err_q) && $stable(sig_q) && $stable(ref_q))); // R1

endmodule

// File: rtl/bit_cond_eval.sv
module bit_cond_eval
   import bit_mon_pkg::*;
#(
   parameter int ERR_W     = 16,
   parameter int AMP_W     = 12,
   parameter int ERR_LIMIT = 100,
   parameter int SIG_FLOOR = 512,
   parameter int REF_FLOOR = 512
) (
   input  logic signed [ERR_W-1:0] err_q,
   input  logic        [AMP_W-1:0] sig_q,
   input  logic        [AMP_W-1:0] ref_q,
   output cond_t                   cond
);

   localparam int MAG_W = ERR_W + 1;
   localparam logic [MAG_W-1:0] LIM_V = MAG_W'(ERR_LIMIT);
   localparam logic [AMP_W-1:0] SIG_V = AMP_W'(SIG_FLOOR);
   localparam logic [AMP_W-1:0] REF_V = AMP_W'(REF_FLOOR);

   logic [MAG_W-1:0] mag;

   generate
      if (ERR_W == 16) begin : g_pkg_mag
         assign mag = mag16(err_q);
      end else begin : g_gen_mag
         logic signed [MAG_W-1:0] wide;
         assign wide = MAG_W'(err_q);
         assign mag  = (wide < 0) ? MAG_W'(-wide) : MAG_W'(wide);
      end
   endgenerate

   always_comb begin
      cond.err_hi  = (mag > LIM_V);
      cond.sig_low = (sig_q < SIG_V);
      cond.ref_low = (ref_q < REF_V);
   end

   always_comb begin
      if (err_q == '0) AST_ZERO_ERR_QUIET: assert (!cond.err_hi); // R2
   end

endmodule

// File: rtl/bit_persist_filter.sv
module bit_persist_filter #(
   parameter int FILT_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_in,
   output logic trip
);

   generate
      if (FILT_CYC == 0) begin : g_bypass
         assign trip = cond_in;
      end else begin : g_count
         localparam int CNT_W = $clog2(FILT_CYC + 1);
         localparam logic [CNT_W-1:0] TERM = CNT_W'(FILT_CYC);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (!cond_in)       cnt <= '0;
            else if (cnt != TERM)    cnt <= cnt + 1'b1;
         end

         assign trip = cond_in && (cnt == TERM);

         AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= TERM); // R3
         AST_RESTART_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !cond_in |=> (cnt == '0)); // R4
         AST_TRIP_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trip) |-> $past(cond_in)); // R3
      end
   endgenerate

endmodule

// File: rtl/bit_fault_monitor.sv
module bit_fault_monitor
   import bit_mon_pkg::*;
#(
   parameter int ERR_W     = 16,
   parameter int AMP_W     = 12,
   parameter int ERR_LIMIT = 100,
   parameter int CLK_HZ    = 50_000_000,
   parameter int FILT_US   = 500,
   parameter int AMP_FS_MV = 4000,
   parameter int LOSS_MV   = 500,
   parameter int SIG_FLOOR = (LOSS_MV * (1 << AMP_W)) / AMP_FS_MV,
   parameter int REF_FLOOR = (LOSS_MV * (1 << AMP_W)) / AMP_FS_MV
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_vld,
   input  logic signed [ERR_W-1:0] err_in,
   input  logic        [AMP_W-1:0] sig_amp,
   input  logic        [AMP_W-1:0] ref_amp,
   output logic                    fault_n
);

   localparam int FILT_CYC = (CLK_HZ / 1_000_000) * FILT_US;

   generate
      if (ERR_W < 2 || ERR_W > 31) begin : g_bad_err_w
         $error("ERR_W out of range");
      end
      if (ERR_LIMIT < 0 || ERR_LIMIT >= (1 << (ERR_W - 1))) begin : g_bad_limit
         $error("ERR_LIMIT does not fit ERR_W");
      end
      if (AMP_W < 2 || AMP_W > 24) begin : g_bad_amp_w
         $error("AMP_W out of range");
      end
      if (SIG_FLOOR < 0 || SIG_FLOOR >= (1 << AMP_W) ||
          REF_FLOOR < 0 || REF_FLOOR >= (1 << AMP_W)) begin : g_bad_floor
         $error("amplitude floor does not fit AMP_W");
      end
      if (FILT_CYC < 0) begin : g_bad_filt
         $error("filter length negative");
      end
   endgenerate

   logic signed [ERR_W-1:0] err_q;
   logic        [AMP_W-1:0] sig_q;
   logic        [AMP_W-1:0] ref_q;
   cond_t                   cond;
   logic                    err_trip;
   logic                    any_fault;

   bit_sample_reg #(.ERR_W(ERR_W), .AMP_W(AMP_W)) u_sample (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .err_in(err_in), .sig_amp(sig_amp), .ref_amp(ref_amp),
      .err_q(err_q), .sig_q(sig_q), .ref_q(ref_q)
   );

   bit_cond_eval #(
      .ERR_W(ERR_W), .AMP_W(AMP_W), .ERR_LIMIT(ERR_LIMIT),
      .SIG_FLOOR(SIG_FLOOR), .REF_FLOOR(REF_FLOOR)
   ) u_eval (
      .err_q(err_q), .sig_q(sig_q), .ref_q(ref_q), .cond(cond)
   );

   bit_persist_filter #(.FILT_CYC(FILT_CYC)) u_filter (
      .clk(clk), .rst_n(rst_n), .cond_in(cond.err_hi), .trip(err_trip)
   );

   assign any_fault = err_trip | cond.sig_low | cond.ref_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_n <= 1'b1;
      else        fault_n <= !any_fault;
   end

   AST_LOS_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cond.sig_low |=> !fault_n); // R5
   AST_LOR_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cond.ref_low |=> !fault_n); // R6
   AST_RELEASE_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_trip && !cond.sig_low && !cond.ref_low) |=> fault_n); // R7
   AST_NO_EARLY_ERR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cond.sig_low && !cond.ref_low && !err_trip) |=> !$fell(fault_n)); // R3

endmodule

// File: tb/bit_fault_monitor_bench.sv
module bit_fault_monitor_bench;

   localparam int CLK_HZ   = 2_000_000;
   localparam int FILT_US  = 500;
   localparam int FILT_CYC = (CLK_HZ / 1_000_000) * FILT_US;
   localparam int GOOD     = 2000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_vld = 1'b0;
   logic signed [15:0] err_in = '0;
   logic        [11:0] sig_amp = '0;
   logic        [11:0] ref_amp = '0;
   logic               fault_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bit_fault_monitor #(.CLK_HZ(CLK_HZ), .FILT_US(FILT_US)) u_bit_fault_monitor (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .err_in(err_in),
      .sig_amp(sig_amp), .ref_amp(ref_amp), .fault_n(fault_n)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (fault_n !== exp) begin
         errors++;
         $display("FAIL %s fault_n=%b expected=%b", req, fault_n, exp);
      end
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Drive one strobe; returns on the falling edge after the capture edge
   task automatic apply(input logic signed [15:0] e, input int s, input int r);
      @(negedge clk);
      err_in = e; sig_amp = 12'(s); ref_amp = 12'(r); smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      err_in = 16'sh7fff; sig_amp = '0; ref_amp = '0;
   endtask

   task automatic to_healthy();
      apply(16'sd0, GOOD, GOOD);
      wait_edges(1);
   endtask

   task automatic t_reset();
      check("R8 reset", 1'b1);
      wait_edges(5);
      check("R8 after reset, no strobe", 1'b1);
   endtask

   task automatic t_err_filter(input logic signed [15:0] e, input string tag);
      to_healthy();
      apply(e, GOOD, GOOD);
      wait_edges(FILT_CYC);
      check({"R3 still high at filter end ", tag}, 1'b1);
      wait_edges(1);
      check({"R3 low after filter ", tag}, 1'b0);
      to_healthy();
      check({"R7 release ", tag}, 1'b1);
   endtask

   task automatic t_below_limit(input logic signed [15:0] e, input string tag);
      to_healthy();
      apply(e, GOOD, GOOD);
      wait_edges(FILT_CYC + 5);
      check({"R2 at limit, no fault ", tag}, 1'b1);
   endtask

   task automatic t_restart();
      to_healthy();
      apply(16'sd500, GOOD, GOOD);
      wait_edges(FILT_CYC / 2);
      apply(16'sd0, GOOD, GOOD);
      apply(-16'sd500, GOOD, GOOD);
      wait_edges(FILT_CYC);
      check("R4 restarted filter still high", 1'b1);
      wait_edges(1);
      check("R4 restarted filter low", 1'b0);
      to_healthy();
   endtask

   task automatic t_los();
      to_healthy();
      apply(16'sd0, 511, GOOD);
      check("R5 before next edge", 1'b1);
      wait_edges(1);
      check("R5 loss of signal", 1'b0);
      to_healthy();
      check("R7 release after LOS", 1'b1);
   endtask

   task automatic t_lor();
      to_healthy();
      apply(16'sd0, GOOD, 0);
      wait_edges(1);
      check("R6 loss of reference", 1'b0);
      to_healthy();
   endtask

   task automatic t_floor_equal();
      to_healthy();
      apply(16'sd0, 512, 512);
      wait_edges(3);
      check("R9 equal to floor is healthy", 1'b1);
   endtask

   task automatic t_hold();
      to_healthy();
      apply(16'sd0, 100, GOOD);
      // inputs now show healthy values but no strobe
      err_in = 16'sd0; sig_amp = 12'(GOOD); ref_amp = 12'(GOOD);
      wait_edges(4);
      check("R1 held without strobe", 1'b0);
      to_healthy();
      check("R1 new strobe clears", 1'b1);
   endtask

   initial begin
      wait_edges(3);
      rst_n = 1'b1;
      t_reset();
      t_err_filter(16'sd101, "+101");
      t_err_filter(-16'sd101, "-101");
      t_err_filter(-16'sd32768, "-32768");
      t_below_limit(16'sd100, "+100");
      t_below_limit(-16'sd100, "-100");
      t_restart();
      t_los();
      t_lor();
      t_floor_equal();
      t_hold();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100_000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule